// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block is a synthesizable model of a small synchronous SRAM whose word is split into byte lanes, each lane holding eight data bits and one parity bit. Every rising clock edge captures the address, write data, three chip-select inputs and the write controls into a request stage. The request is then carried out in the next cycle. A write commits its selected lanes to the array at the end of that cycle. A read loads an output register, which presents the word together with a valid flag.

Three select inputs allow several instances to share one bus, in the way depth expansion does. Because the select decode is registered, a bank that is deselected still delivers a read it has already accepted before it goes quiet. The data output is a stream with no back-pressure: `rd_valid` is high for exactly one cycle per accepted read, and the consumer must take the word in that cycle. A global-write input overrides the per-lane enables. An asynchronous output enable gates the output, and a snooze input stops the block from accepting any new access. Burst address generation is not part of this block; every access supplies its own address.

Top module: `bytelane_sync_sram`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `rd_valid` is 0 and `rd_data` is all zeros.
- R2: An access is accepted at a clock edge only if all three selects are active: `sel_a_n`=0, `sel_hi`=1 and `sel_b_n`=0. If any select is inactive, the edge produces neither a write nor a read response.
- R3: With `gwr_n`=0 and the block selected, the edge captures a write of all lanes, whatever `bwr_n` and `lane_wr_n` are.
- R4: With `gwr_n`=1 and `bwr_n`=0, the edge captures a write of each lane whose `lane_wr_n` bit is 0. Lane 0 is `wr_data[8:0]` (data bits [7:0], parity bit 8) and lane 1 is `wr_data[17:9]`. Lanes that are not written keep their stored contents.
- R5: With `gwr_n`=1 and either `bwr_n`=1 or all `lane_wr_n` bits 1, a selected edge is a read. The stored word appears on `rd_data` with `rd_valid`=1 during the cycle after the next edge, for that one cycle only.
- R6: A read captured at the edge right after a write to the same address returns the newly written lanes merged with the untouched ones (write pass-through).
- R7: `rd_oe_n`=1 forces `rd_valid` to 0 and `rd_data` to zero with no clock edge involved. Driving it back to 0 restores the held word in the same cycle.
- R8: While a write is held in the request stage, the output is not driven: `rd_valid` is 0 and `rd_data` is zero, even if a read response is pending.
- R9: With `snooze`=1 at an edge, no access is accepted and any pending read response is cleared, so `rd_valid` is 0 in the following cycle. A write presented during snooze leaves the array unchanged.
- R10: Deselection is pipelined. If a read is accepted at edge N and the block is deselected at edge N+1, the read response still appears after edge N+1. The deselected edge itself yields `rd_valid`=0 one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (6) | Word address, registered |
| wr_data | input | LANES*LANE_BITS (18) | Write data, lane 0 in the low bits |
| sel_a_n | input | 1 | Select, active low |
| sel_hi | input | 1 | Select, active high |
| sel_b_n | input | 1 | Select, active low |
| gwr_n | input | 1 | Global write of all lanes, active low |
| bwr_n | input | 1 | Qualifies the per-lane write enables, active low |
| lane_wr_n | input | LANES (2) | Per-lane write enables, active low |
| snooze | input | 1 | Standby: refuse accesses, active high |
| rd_oe_n | input | 1 | Asynchronous output enable, active low |
| rd_data | output | LANES*LANE_BITS (18) | Read word, zero when not driven |
| rd_valid | output | 1 | Read word valid this cycle |

## Verification
Some properties are checked on every cycle. An inactive select never turns into an accepted request, a global write always captures every lane, and the array is never written with an empty lane mask. After a snooze edge the output is quiet, and a valid output always traces back to a read held in the request stage one edge earlier. The data itself can only be shown by the bench's scenarios: lane merging, pass-through on a back-to-back read, the global-write override, a read whose response arrives after deselection, and the fact that a write made during snooze changes nothing.

// File: rtl/bytelane_sram_pkg.sv
package bytelane_sram_pkg;
  typedef enum logic [1:0] {
    REQ_IDLE  = 2'd0,
    REQ_READ  = 2'd1,
    REQ_WRITE = 2'd2
  } req_op_e;
endpackage

// File: rtl/sram_req_stage.sv
module sram_req_stage
  import bytelane_sram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned LANES     = 2,
  parameter int unsigned LANE_BITS = 9,
  localparam int unsigned WORD_W   = LANES * LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              sel_a_n,
  input  logic              sel_hi,
  input  logic              sel_b_n,
  input  logic              gwr_n,
  input  logic              bwr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              snooze,
  output req_op_e           req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [WORD_W-1:0] req_data,
  output logic [LANES-1:0]  req_lanes
);
  logic             selected;
  logic [LANES-1:0] lanes_c;
  req_op_e          op_c;

  always_comb begin
    selected = !sel_a_n && sel_hi && !sel_b_n;
    if (!gwr_n)      lanes_c = '1;
    else if (!bwr_n) lanes_c = ~lane_wr_n;
    else             lanes_c = '0;
    if (!selected || snooze) op_c = REQ_IDLE;
    else if (|lanes_c)       op_c = REQ_WRITE;
    else                     op_c = REQ_READ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_op    <= REQ_IDLE;
      req_addr  <= '0;
      req_data  <= '0;
      req_lanes <= '0;
    end else begin
      req_op    <= op_c;
      req_addr  <= addr;
      req_data  <= wr_data;
      req_lanes <= (op_c == REQ_WRITE) ? lanes_c : '0;
    end
  end

  // R2
  unselected_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_n || !sel_hi || sel_b_n) |=> (req_op == REQ_IDLE));

  // R3
  global_write_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gwr_n && !sel_a_n && sel_hi && !sel_b_n && !snooze) |=>
      (req_op == REQ_WRITE && req_lanes == {LANES{1'b1}}));
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned LANES     = 2,
  parameter int unsigned LANE_BITS = 9,
  localparam int unsigned ADDR_W   = $clog2(DEPTH),
  localparam int unsigned WORD_W   = LANES * LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [LANES-1:0]  wr_lanes,
  output logic [WORD_W-1:0] rd_word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_BITS-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_lanes[g])
        mem[addr] <= wr_word[g*LANE_BITS +: LANE_BITS];
    end

    assign rd_word[g*LANE_BITS +: LANE_BITS] = mem[addr];
  end

  // R4
  write_has_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_lanes != '0));
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
  parameter int unsigned WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snooze,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_word,
  input  logic              write_held,
  input  logic              rd_oe_n,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  logic              held_vld;
  logic [WORD_W-1:0] held_word;
  logic              drive;

  always_ff @(posedge clk) begin
    if (!rst_n || snooze) begin
      held_vld  <= 1'b0;
      held_word <= '0;
    end else begin
      held_vld <= load_en;
      if (load_en) held_word <= load_word;
    end
  end

  always_comb begin
    drive    = held_vld && !rd_oe_n && !write_held;
    rd_valid = drive;
    rd_data  = drive ? held_word : '0;
  end

  // R9
  snooze_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |=> !rd_valid);

  // R5
  valid_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(load_en));
endmodule

// File: rtl/bytelane_sync_sram.sv
module bytelane_sync_sram
  import bytelane_sram_pkg::*;
#(
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned LANES     = 2,
  parameter int unsigned LANE_BITS = 9,
  localparam int unsigned ADDR_W   = $clog2(DEPTH),
  localparam int unsigned WORD_W   = LANES * LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              sel_a_n,
  input  logic              sel_hi,
  input  logic              sel_b_n,
  input  logic              gwr_n,
  input  logic              bwr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              snooze,
  input  logic              rd_oe_n,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  req_op_e           req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [WORD_W-1:0] req_data;
  logic [LANES-1:0]  req_lanes;
  logic [WORD_W-1:0] arr_word;

  sram_req_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_BITS(LANE_BITS)) u_req (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .sel_a_n(sel_a_n), .sel_hi(sel_hi), .sel_b_n(sel_b_n),
    .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n), .snooze(snooze),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_lanes(req_lanes)
  );

  sram_lane_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_BITS(LANE_BITS)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(req_op == REQ_WRITE), .addr(req_addr),
    .wr_word(req_data), .wr_lanes(req_lanes), .rd_word(arr_word)
  );

  sram_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .snooze(snooze),
    .load_en(req_op == REQ_READ), .load_word(arr_word),
    .write_held(req_op == REQ_WRITE), .rd_oe_n(rd_oe_n),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/tb_bytelane_sync_sram.sv
module tb_bytelane_sync_sram;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  cs;      // {sel_a_n, sel_hi, sel_b_n}
    logic        gw_n;
    logic        bw_n;
    logic [1:0]  we_n;
    logic [5:0]  a;
    logic [17:0] wd;
    logic        ev;
    logic [17:0] ed;
  } vec_t;

  localparam logic [2:0] SEL = 3'b010;
  localparam int NV = 15;
  localparam vec_t V [NV] = '{
    '{SEL,    1'b0, 1'b1, 2'b11, 6'd5, 18'h2A5A5, 1'b0, 18'h0},       // R3 full write
    '{SEL,    1'b1, 1'b1, 2'b11, 6'd5, 18'h0,     1'b0, 18'h0},       // R5 read
    '{3'b110, 1'b1, 1'b1, 2'b11, 6'd0, 18'h0,     1'b1, 18'h2A5A5},   // R10 deselect after read
    '{SEL,    1'b1, 1'b0, 2'b10, 6'd5, 18'h000C3, 1'b0, 18'h0},       // R4 lane 0 write
    '{SEL,    1'b1, 1'b1, 2'b11, 6'd5, 18'h0,     1'b0, 18'h0},       // R6 read right after
    '{3'b000, 1'b1, 1'b1, 2'b11, 6'd5, 18'h0,     1'b1, 18'h2A4C3},   // R6 merged word
    '{SEL,    1'b0, 1'b1, 2'b11, 6'd9, 18'h00000, 1'b0, 18'h0},       // R2 previous edge idle
    '{SEL,    1'b1, 1'b0, 2'b01, 6'd9, 18'h3FFFF, 1'b0, 18'h0},       // R4 lane 1 write
    '{SEL,    1'b1, 1'b1, 2'b00, 6'd9, 18'h12345, 1'b0, 18'h0},       // R5 lanes ignored: read
    '{SEL,    1'b1, 1'b1, 2'b11, 6'd9, 18'h0,     1'b1, 18'h3FE00},   // R4 lane 1 only
    '{3'b011, 1'b1, 1'b1, 2'b11, 6'd5, 18'h0,     1'b1, 18'h3FE00},   // R10
    '{3'b110, 1'b1, 1'b1, 2'b11, 6'd5, 18'h0,     1'b0, 18'h0},       // R2 deselected edge
    '{SEL,    1'b0, 1'b0, 2'b11, 6'd9, 18'h15555, 1'b0, 18'h0},       // R3 override
    '{SEL,    1'b1, 1'b1, 2'b11, 6'd9, 18'h0,     1'b0, 18'h0},
    '{3'b110, 1'b1, 1'b1, 2'b11, 6'd0, 18'h0,     1'b1, 18'h15555}    // R3 all lanes
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [17:0] wr_data = '0;
  logic        sel_a_n = 1'b1, sel_hi = 1'b1, sel_b_n = 1'b0;
  logic        gwr_n = 1'b1, bwr_n = 1'b1;
  logic [1:0]  lane_wr_n = 2'b11;
  logic        snooze = 1'b0, rd_oe_n = 1'b0;
  logic [17:0] rd_data;
  logic        rd_valid;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bytelane_sync_sram dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .sel_a_n(sel_a_n), .sel_hi(sel_hi), .sel_b_n(sel_b_n),
    .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n),
    .snooze(snooze), .rd_oe_n(rd_oe_n), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input string req, input logic ev, input logic [17:0] ed);
    checks++;
    if (rd_valid !== ev || rd_data !== ed) begin
      failures++;
      $display("FAIL %s: got valid=%0b data=%05h, expected valid=%0b data=%05h",
               req, rd_valid, rd_data, ev, ed);
    end
  endtask

  task automatic step(input logic [2:0] cs, input logic g, input logic b,
                      input logic [1:0] w, input logic [5:0] a, input logic [17:0] d);
    @(negedge clk);
    {sel_a_n, sel_hi, sel_b_n} = cs;
    gwr_n = g; bwr_n = b; lane_wr_n = w; addr = a; wr_data = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", 1'b0, 18'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 check("R1 after release", 1'b0, 18'h0);

    for (int i = 0; i < NV; i++) begin
      step(V[i].cs, V[i].gw_n, V[i].bw_n, V[i].we_n, V[i].a, V[i].wd);
      check($sformatf("R2-table row %0d (R4 R5 R6 R10)", i), V[i].ev, V[i].ed);
    end

    // R7: asynchronous output enable
    step(SEL, 1'b0, 1'b1, 2'b11, 6'd3, 18'h11111);
    step(SEL, 1'b1, 1'b1, 2'b11, 6'd3, 18'h0);
    step(3'b110, 1'b1, 1'b1, 2'b11, 6'd0, 18'h0);
    check("R7 enabled", 1'b1, 18'h11111);
    rd_oe_n = 1'b1; #1 check("R7 disabled", 1'b0, 18'h0);
    rd_oe_n = 1'b0; #1 check("R7 re-enabled", 1'b1, 18'h11111);

    // R8: write held in request stage hides a pending read response
    step(SEL, 1'b1, 1'b1, 2'b11, 6'd3, 18'h0);
    step(SEL, 1'b0, 1'b1, 2'b11, 6'd4, 18'h0ABCD);
    check("R8 write cycle", 1'b0, 18'h0);
    step(3'b110, 1'b1, 1'b1, 2'b11, 6'd0, 18'h0);
    check("R8 after write", 1'b0, 18'h0);

    // R9: snooze drops a pending read and refuses a write
    step(SEL, 1'b1, 1'b1, 2'b11, 6'd3, 18'h0);
    @(negedge clk); snooze = 1'b1;
    step(SEL, 1'b0, 1'b1, 2'b11, 6'd3, 18'h2BCDE);
    check("R9 pending read dropped", 1'b0, 18'h0);
    step(SEL, 1'b1, 1'b1, 2'b11, 6'd3, 18'h0);
    check("R9 read refused", 1'b0, 18'h0);
    @(negedge clk); snooze = 1'b0;
    step(SEL, 1'b1, 1'b1, 2'b11, 6'd3, 18'h0);
    step(3'b110, 1'b1, 1'b1, 2'b11, 6'd0, 18'h0);
    check("R9 write ignored", 1'b1, 18'h11111);
    step(SEL, 1'b1, 1'b1, 2'b11, 6'd4, 18'h0);
    step(3'b110, 1'b1, 1'b1, 2'b11, 6'd0, 18'h0);
    check("R8 write committed", 1'b1, 18'h0ABCD);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule